// File: doc/BRIEF.md
# Segment Table Address Translator

This block turns a two-part logical address, made of a segment number and an offset within that segment, into a flat physical address. It keeps a small table of segment descriptors in internal registers. Each descriptor holds the physical start address of its segment and the segment's size. A separate length register says how many descriptors are in use. Only segment numbers below that count are accepted.

Each lookup is checked twice. First, the segment number must lie below the length register. Second, the offset must lie below the selected descriptor's size. Only when both checks pass does the block add the start address to the offset. A failed check returns a two-bit trap code in place of an address. Lookups take one cycle: the descriptor and the segment check are registered at issue, and the offset check and the addition follow from those registers. The same port that loads descriptors also loads the length register.

Top module: `seg_xlate`

## Requirements
- R1: After reset, rsp_valid is 0 and the length register is 0, so every lookup until the first length write returns trap code 01.
- R2: rsp_valid is 1 exactly one cycle after a cycle with req_valid at 1, and 0 otherwise. While rsp_valid is 0, rsp_trap and rsp_pa are both 0.
- R3: A lookup whose segment number is greater than or equal to the length register returns rsp_trap = 01 and rsp_pa = 0.
- R4: A lookup with a legal segment number and an offset greater than or equal to that descriptor's limit returns rsp_trap = 10 and rsp_pa = 0.
- R5: A lookup that passes both checks returns rsp_trap = 00 and rsp_pa = (base + offset) modulo 2^PA_W.
- R6: When both checks fail, the segment check wins and the trap code is 01.
- R7: A write (wr_len_sel = 0: descriptor wr_idx gets wr_base and wr_limit; wr_len_sel = 1: the length register gets wr_len) is seen by lookups issued in the next cycle and later. A lookup issued in the same cycle as the write sees the old value.
- R8: The bounds are exclusive. Segment length-1 and offset limit-1 are legal. A limit of 2^OFF_W makes every offset legal.
- R9: Trap code 11 is never produced.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Lookup request |
| req_seg | input | SEG_W | Segment number |
| req_off | input | OFF_W | Offset within segment |
| wr_en | input | 1 | Table write strobe |
| wr_len_sel | input | 1 | 1 writes the length register, 0 writes a descriptor |
| wr_idx | input | SEG_W | Descriptor index for writes |
| wr_base | input | PA_W | Segment start address to write |
| wr_limit | input | OFF_W+1 | Segment size to write |
| wr_len | input | SEG_W+1 | Number of segments in use |
| rsp_valid | output | 1 | Result valid |
| rsp_trap | output | 2 | 00 ok, 01 segment out of range, 10 offset out of range |
| rsp_pa | output | PA_W | Physical address; 0 on a trap |

## Verification
The assertions check on every cycle that the response follows a request by one cycle, that an idle response carries zeros, and that a trap never carries an address and never uses code 11. They also keep their own copy of the length register, loaded through the write port, and use it to check the segment range trap. The offset bound, the exact sums including wraparound, the priority when both checks fail, and the timing of a write that collides with a lookup depend on descriptor contents. Only the bench scenarios show those.

// File: rtl/seg_xlate.sv
module seg_xlate #(
  parameter int SEG_W = 3,
  parameter int OFF_W = 12,
  parameter int PA_W  = 16
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               req_valid,
  input  logic [SEG_W-1:0]   req_seg,
  input  logic [OFF_W-1:0]   req_off,
  input  logic               wr_en,
  input  logic               wr_len_sel,
  input  logic [SEG_W-1:0]   wr_idx,
  input  logic [PA_W-1:0]    wr_base,
  input  logic [OFF_W:0]     wr_limit,
  input  logic [SEG_W:0]     wr_len,
  output logic               rsp_valid,
  output logic [1:0]         rsp_trap,
  output logic [PA_W-1:0]    rsp_pa
);
  localparam int NSEG = 1 << SEG_W;

  logic [PA_W-1:0]  base_q [NSEG];
  logic [OFF_W:0]   lim_q  [NSEG];
  logic [SEG_W:0]   len_q;

  logic             v1;
  logic             seg_ok1;
  logic [PA_W-1:0]  base1;
  logic [OFF_W:0]   lim1;
  logic [OFF_W-1:0] off1;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      len_q <= '0;
      for (int i = 0; i < NSEG; i++) begin
        base_q[i] <= '0;
        lim_q[i]  <= '0;
      end
    end else if (wr_en) begin
      if (wr_len_sel) len_q <= wr_len;
      else begin
        base_q[wr_idx] <= wr_base;
        lim_q[wr_idx]  <= wr_limit;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      v1      <= 1'b0;
      seg_ok1 <= 1'b0;
      base1   <= '0;
      lim1    <= '0;
      off1    <= '0;
    end else begin
      v1      <= req_valid;
      seg_ok1 <= {1'b0, req_seg} < len_q;
      base1   <= base_q[req_seg];
      lim1    <= lim_q[req_seg];
      off1    <= req_off;
    end
  end

  wire off_ok = {1'b0, off1} < lim1;
  wire [1:0] trap = !seg_ok1 ? 2'b01 : (!off_ok ? 2'b10 : 2'b00);
  wire [PA_W-1:0] sum = base1 + {{(PA_W-OFF_W){1'b0}}, off1};

  assign rsp_valid = v1;
  assign rsp_trap  = v1 ? trap : 2'b00;
  assign rsp_pa    = (v1 && trap == 2'b00) ? sum : '0;
endmodule

// File: rtl/seg_xlate_chk.sv
module seg_xlate_chk #(
  parameter int SEG_W = 3,
  parameter int PA_W  = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             req_valid,
  input logic [SEG_W-1:0] req_seg,
  input logic             wr_en,
  input logic             wr_len_sel,
  input logic [SEG_W:0]   wr_len,
  input logic             rsp_valid,
  input logic [1:0]       rsp_trap,
  input logic [PA_W-1:0]  rsp_pa
);
  logic [SEG_W:0] sh_len;
  always_ff @(posedge clk) begin
    if (!rst_n) sh_len <= '0;
    else if (wr_en && wr_len_sel) sh_len <= wr_len;
  end

  a_r2_resp_follows: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> rsp_valid);
  a_r2_no_spurious: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |=> !rsp_valid);
  a_r2_idle_zero: assert property (@(posedge clk) disable iff (!rst_n)
    !rsp_valid |-> (rsp_trap == 2'b00 && rsp_pa == '0));
  a_r3_seg_range: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && {1'b0, req_seg} >= sh_len) |=> rsp_trap == 2'b01);
  a_r4_trap_no_addr: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_trap != 2'b00) |-> rsp_pa == '0);
  a_r9_no_code3: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_trap != 2'b11);
endmodule

bind seg_xlate seg_xlate_chk #(.SEG_W(SEG_W), .PA_W(PA_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_seg(req_seg),
  .wr_en(wr_en), .wr_len_sel(wr_len_sel), .wr_len(wr_len),
  .rsp_valid(rsp_valid), .rsp_trap(rsp_trap), .rsp_pa(rsp_pa)
);

// File: tb/seg_xlate_tb.sv
module seg_xlate_tb;
  localparam int SEG_W = 3;
  localparam int OFF_W = 12;
  localparam int PA_W  = 16;

  logic clk = 0;
  logic rst_n = 0;
  logic req_valid = 0;
  logic [SEG_W-1:0] req_seg = '0;
  logic [OFF_W-1:0] req_off = '0;
  logic wr_en = 0, wr_len_sel = 0;
  logic [SEG_W-1:0] wr_idx = '0;
  logic [PA_W-1:0] wr_base = '0;
  logic [OFF_W:0] wr_limit = '0;
  logic [SEG_W:0] wr_len = '0;
  logic rsp_valid;
  logic [1:0] rsp_trap;
  logic [PA_W-1:0] rsp_pa;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #4 clk = ~clk;

  seg_xlate #(.SEG_W(SEG_W), .OFF_W(OFF_W), .PA_W(PA_W)) u_dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_seg(req_seg),
    .req_off(req_off), .wr_en(wr_en), .wr_len_sel(wr_len_sel), .wr_idx(wr_idx),
    .wr_base(wr_base), .wr_limit(wr_limit), .wr_len(wr_len),
    .rsp_valid(rsp_valid), .rsp_trap(rsp_trap), .rsp_pa(rsp_pa)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic put_entry(input int idx, input logic [PA_W-1:0] b, input logic [OFF_W:0] l);
    @(negedge clk);
    wr_en = 1; wr_len_sel = 0; wr_idx = idx[SEG_W-1:0]; wr_base = b; wr_limit = l;
    @(negedge clk);
    wr_en = 0;
  endtask

  task automatic put_len(input int n);
    @(negedge clk);
    wr_en = 1; wr_len_sel = 1; wr_len = n[SEG_W:0];
    @(negedge clk);
    wr_en = 0;
  endtask

  task automatic look(input string tag, input int s, input int o,
                      input logic [1:0] et, input logic [PA_W-1:0] ep);
    @(negedge clk);
    req_valid = 1; req_seg = s[SEG_W-1:0]; req_off = o[OFF_W-1:0];
    @(negedge clk);
    req_valid = 0;
    chk({tag, " R2 valid"}, 32'(rsp_valid), 1);
    chk({tag, " trap"}, 32'(rsp_trap), 32'(et));
    chk({tag, " pa"}, 32'(rsp_pa), 32'(ep));
  endtask

  task automatic t_reset;
    chk("R1 valid after reset", 32'(rsp_valid), 0);
    look("R1 seg0 before length write", 0, 0, 2'b01, 16'h0);
    @(negedge clk);
    chk("R2 idle valid", 32'(rsp_valid), 0);
    chk("R2 idle trap", 32'(rsp_trap), 0);
    chk("R2 idle pa", 32'(rsp_pa), 0);
  endtask

  task automatic t_legal;
    put_entry(0, 16'h1000, 13'd256);
    put_entry(1, 16'h2400, 13'd100);
    put_entry(2, 16'hFF00, 13'd4096);
    put_entry(3, 16'h0800, 13'd16);
    put_len(4);
    look("R5 seg1", 1, 5, 2'b00, 16'h2405);
    look("R5 seg0", 0, 255, 2'b00, 16'h10FF);
    look("R5 wrap", 2, 16'h200, 2'b00, 16'h0100);
    look("R8 full limit", 2, 4095, 2'b00, 16'h0EFF);
  endtask

  task automatic t_offset;
    look("R4 off==limit", 1, 100, 2'b10, 16'h0);
    look("R8 off==limit-1", 1, 99, 2'b00, 16'h2463);
    look("R4 off large", 3, 4000, 2'b10, 16'h0);
  endtask

  task automatic t_segment;
    look("R3 seg==len", 4, 0, 2'b01, 16'h0);
    look("R8 seg==len-1", 3, 15, 2'b00, 16'h080F);
    put_entry(6, 16'h3000, 13'd8);
    look("R6 both fail", 6, 200, 2'b01, 16'h0);
    look("R3 seg7", 7, 0, 2'b01, 16'h0);
  endtask

  task automatic t_same_cycle;
    @(negedge clk);
    wr_en = 1; wr_len_sel = 0; wr_idx = 1; wr_base = 16'h5000; wr_limit = 13'd100;
    req_valid = 1; req_seg = 1; req_off = 7;
    @(negedge clk);
    wr_en = 0; req_valid = 0;
    chk("R7 same-cycle old base", 32'(rsp_pa), 32'h2407);
    look("R7 next-cycle new base", 1, 7, 2'b00, 16'h5007);
    @(negedge clk);
    wr_en = 1; wr_len_sel = 1; wr_len = 7;
    req_valid = 1; req_seg = 6; req_off = 3;
    @(negedge clk);
    wr_en = 0; req_valid = 0;
    chk("R7 same-cycle old length", 32'(rsp_trap), 32'h1);
    look("R7 next-cycle new length", 6, 3, 2'b00, 16'h3003);
  endtask

  task automatic t_back_to_back;
    @(negedge clk);
    req_valid = 1; req_seg = 0; req_off = 1;
    @(negedge clk);
    req_seg = 7; req_off = 0;
    chk("R2 b2b first valid", 32'(rsp_valid), 1);
    chk("R5 b2b first pa", 32'(rsp_pa), 32'h1001);
    @(negedge clk);
    req_valid = 0;
    chk("R3 b2b second trap", 32'(rsp_trap), 32'h1);
    @(negedge clk);
    chk("R2 b2b drop", 32'(rsp_valid), 0);
  endtask

  initial begin
    #(8 * 200000);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset;
    t_legal;
    t_offset;
    t_segment;
    t_same_cycle;
    t_back_to_back;
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule